// File: doc/BRIEF.md
# Masked Interrupt Request Controller

This block gathers single-cycle request pulses from eleven peripheral sources of a small 4-bit microcontroller. It keeps each pulse in a pending register only when that source's mask bit is already set. Masking therefore acts at capture time. A request that arrives while its mask is clear is lost. Setting the mask later does not bring it back.

The CPU sees three 4-bit pending registers and three 4-bit mask registers on a small register bus. It clears pending bits by writing ones to them.

A single registered interrupt line goes to the core. It is the OR of all pending bits, gated by a global enable bit and by an externally owned auto-mode flag. The global enable is written by the core. It is also forced on when the core enters halt, so that a pending request can wake it. The auto-mode flag suppresses that forcing and holds the interrupt line low for as long as it is set.

Top module: `irq_latch_ctrl`

## Requirements
- R1: A source pulse on `src_req[n]` is stored in its pending bit only if the matching mask bit is 1 at that clock edge. With the mask bit at 0 the pulse is dropped and the pending bit stays 0.
- R2: Capturing a request depends on the mask bit alone. The values of `ien` and `auto_mode` have no effect on whether a pending bit is set.
- R3: A bus write to a pending register clears every bit written as 1 and leaves every bit written as 0 unchanged. A read returns the current pending bits.
- R4: When a new masked request and a write-1 clear hit the same pending bit in the same cycle, the bit ends up set.
- R5: Source `src_req[n]` maps to pending register `n/4`, bit `n%4`. The sources are:
  - indices 3..0: port pins 3..0
  - index 4: ADC
  - index 5: EEPROM
  - index 6: 32/8 Hz tick
  - index 7: 1 Hz tick
  - index 8: counter compare
  - index 9: counter zero
  - index 10: voltage-level detect
- R6: Pending registers sit at bus addresses 0, 1, 2 and mask registers at 3, 4, 5. Masks are plain read/write and mirror their pending register bit for bit. All pending, mask and enable state resets to 0. Bit 3 of address 2 and of address 5 always reads 0, and addresses 6 and 7 read 0.
- R7: `cpu_irq` is registered. One cycle after any pending bit is set while `ien` is 1 and `auto_mode` is 0, it is 1. Otherwise it is 0 one cycle later.
- R8: A `halt_enter` pulse while `auto_mode` is 0 sets `ien` to 1 at that edge. This overrides an `ien_we` write in the same cycle.
- R9: While `auto_mode` is 1, a `halt_enter` pulse leaves `ien` unchanged, and `cpu_irq` is 0 from the next cycle on. Once `auto_mode` returns to 0, the line follows R7 again.
- R10: `ien_we` loads `ien_wdata` into `ien` at the clock edge, unless R8 applies.
- R11: `bus_rdata` is loaded at the edge where `bus_rd` is 1, with the register selected by `bus_addr`. It holds its value in every cycle where `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 11 | Single-cycle request pulses, one per source |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 4 | Write data |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_rdata | output | 4 | Registered read data |
| ien_we | input | 1 | Global enable write strobe from the core |
| ien_wdata | input | 1 | Global enable write value |
| halt_enter | input | 1 | Pulse when the core enters halt |
| auto_mode | input | 1 | Auto-mode flag; blocks halt forcing and the interrupt line |
| ien | output | 1 | Global interrupt enable state |
| cpu_irq | output | 1 | Registered interrupt request to the core |

## Verification
The capture path is exercised with a table of mask and source patterns, each a different combination over all three registers:
- All masks clear with all sources active, which separates capture-time masking from issue-time masking.
- All masks set.
- Alternating masks with partial sources, which expose any swapped bit or register.
- Sparse overlaps whose AND leaves a single bit.

Directed sequences then cover the remaining cases:
- Partial write-1 clears and zero writes, which separate clear-on-one from plain load.
- A simultaneous request and clear on the same bit.
- Capture while the enable is off and auto mode is on.
- Halt entry with and without auto mode, including a colliding enable write.
- The unused bit and address positions.
- Read data holding between strobes.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  // Number of DW-wide register banks needed for nsrc sources.
  function automatic int bank_count(input int nsrc, input int dw);
    return (nsrc + dw - 1) / dw;
  endfunction

  // Bits of bank b that are backed by a real source.
  function automatic logic [31:0] bank_valid(input int b, input int dw, input int nsrc);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < dw; i++) begin
      if (b * dw + i < nsrc) v[i] = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int DW = 4,
  parameter logic [DW-1:0] VALID = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] req,
  input  logic          clr_we,
  input  logic          mask_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] pend,
  output logic [DW-1:0] mask
);

  logic [DW-1:0] clr_bits;
  logic [DW-1:0] take_bits;

  assign clr_bits  = clr_we ? wdata : '0;
  assign take_bits = req & mask & VALID;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
    end else if (mask_we) begin
      mask <= wdata & VALID;
    end
  end

  // New capture wins over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      pend <= (pend & ~clr_bits) | take_bits;
    end
  end

  // R1: a bit can only rise if a masked request was present the cycle before
  a_r1_no_unmasked_capture: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend) & ~$past(req & mask)) == '0));

  // R4: a masked request always leaves its bit set, clear or not
  a_r4_new_request_wins: assert property (@(posedge clk) disable iff (rst)
    ((pend & $past(req & mask)) == $past(req & mask)));

  // R3: a bit can only fall where a 1 was written to it
  a_r3_clear_only_by_write: assert property (@(posedge clk) disable iff (rst)
    (($past(pend) & ~pend & ~$past(clr_we ? wdata : '0)) == '0));

endmodule

// File: rtl/irq_regbus.sv
module irq_regbus #(
  parameter int DW    = 4,
  parameter int NBANK = 3,
  parameter int AW    = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [AW-1:0]              bus_addr,
  input  logic [DW-1:0]              bus_wdata,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [NBANK-1:0][DW-1:0]   pend_all,
  input  logic [NBANK-1:0][DW-1:0]   mask_all,
  output logic [NBANK-1:0]           clr_we,
  output logic [NBANK-1:0]           mask_we,
  output logic [DW-1:0]              wdata,
  output logic [DW-1:0]              bus_rdata
);

  logic [DW-1:0] rd_mux;

  assign wdata = bus_wdata;

  // Pending banks at 0..NBANK-1, mask banks at NBANK..2*NBANK-1.
  for (genvar b = 0; b < NBANK; b++) begin : g_dec
    assign clr_we[b]  = bus_wr && (bus_addr == AW'(b));
    assign mask_we[b] = bus_wr && (bus_addr == AW'(NBANK + b));
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bus_addr == AW'(b))         rd_mux = pend_all[b];
      if (bus_addr == AW'(NBANK + b)) rd_mux = mask_all[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end

  // R11: read data holds between read strobes
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: rtl/irq_enable.sv
module irq_enable (
  input  logic clk,
  input  logic rst,
  input  logic ien_we,
  input  logic ien_wdata,
  input  logic halt_enter,
  input  logic auto_mode,
  input  logic any_pend,
  output logic ien,
  output logic cpu_irq
);

  logic halt_force;

  assign halt_force = halt_enter && !auto_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= 1'b0;
    end else if (halt_force) begin
      ien <= 1'b1;
    end else if (ien_we) begin
      ien <= ien_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq <= 1'b0;
    end else begin
      cpu_irq <= any_pend && ien && !auto_mode;
    end
  end

  // R8: halt entry without auto mode sets the enable
  a_r8_halt_sets_enable: assert property (@(posedge clk) disable iff (rst)
    (halt_enter && !auto_mode) |=> ien);

  // R9: auto mode holds the line low
  a_r9_auto_blocks_irq: assert property (@(posedge clk) disable iff (rst)
    auto_mode |=> !cpu_irq);

  // R7: the line rises for enabled pending state
  a_r7_irq_rises: assert property (@(posedge clk) disable iff (rst)
    (any_pend && ien && !auto_mode) |=> cpu_irq);

  // R7: the line falls without pending state
  a_r7_irq_needs_pend: assert property (@(posedge clk) disable iff (rst)
    !any_pend |=> !cpu_irq);

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int NUM_SRC = 11,
  parameter int DW      = 4,
  parameter int AW      = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [DW-1:0]      bus_rdata,
  input  logic               ien_we,
  input  logic               ien_wdata,
  input  logic               halt_enter,
  input  logic               auto_mode,
  output logic               ien,
  output logic               cpu_irq
);

  localparam int NBANK = irq_latch_pkg::bank_count(NUM_SRC, DW);
  localparam int FLAT  = NBANK * DW;

  logic [FLAT-1:0]            src_pad;
  logic [NBANK-1:0][DW-1:0]   pend_all;
  logic [NBANK-1:0][DW-1:0]   mask_all;
  logic [FLAT-1:0]            pend_flat;
  logic [FLAT-1:0]            mask_flat;
  logic [NBANK-1:0]           clr_we;
  logic [NBANK-1:0]           mask_we;
  logic [DW-1:0]              wdata;
  logic                       any_pend;

  assign src_pad   = FLAT'(src_req);
  assign pend_flat = pend_all;
  assign mask_flat = mask_all;
  assign any_pend  = |pend_flat;

  irq_regbus #(.DW(DW), .NBANK(NBANK), .AW(AW)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .pend_all  (pend_all),
    .mask_all  (mask_all),
    .clr_we    (clr_we),
    .mask_we   (mask_we),
    .wdata     (wdata),
    .bus_rdata (bus_rdata)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [DW-1:0] VB = DW'(irq_latch_pkg::bank_valid(b, DW, NUM_SRC));
    irq_bank #(.DW(DW), .VALID(VB)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .req     (src_pad[b*DW +: DW]),
      .clr_we  (clr_we[b]),
      .mask_we (mask_we[b]),
      .wdata   (wdata),
      .pend    (pend_all[b]),
      .mask    (mask_all[b])
    );
  end

  irq_enable u_en (
    .clk        (clk),
    .rst        (rst),
    .ien_we     (ien_we),
    .ien_wdata  (ien_wdata),
    .halt_enter (halt_enter),
    .auto_mode  (auto_mode),
    .any_pend   (any_pend),
    .ien        (ien),
    .cpu_irq    (cpu_irq)
  );

  // R5: the highest source lands in the last backed position
  a_r5_top_source_map: assert property (@(posedge clk) disable iff (rst)
    (src_req[NUM_SRC-1] && mask_flat[NUM_SRC-1]) |=> pend_flat[NUM_SRC-1]);

  // R6: positions without a source never hold state
  a_r6_unbacked_zero: assert property (@(posedge clk) disable iff (rst)
    ((pend_flat | mask_flat) >> NUM_SRC) == '0);

endmodule

// File: tb/irq_latch_ctrl_test.sv
module irq_latch_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] src_req = '0;
  logic [2:0]  bus_addr = '0;
  logic [3:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_rdata;
  logic        ien_we = 1'b0;
  logic        ien_wdata = 1'b0;
  logic        halt_enter = 1'b0;
  logic        auto_mode = 1'b0;
  logic        ien;
  logic        cpu_irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_latch_ctrl uut (
    .clk(clk), .rst(rst), .src_req(src_req), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .ien_we(ien_we), .ien_wdata(ien_wdata),
    .halt_enter(halt_enter), .auto_mode(auto_mode), .ien(ien),
    .cpu_irq(cpu_irq)
  );

  // {mask[11:0], src[11:0], expected pending[11:0]}, banks packed low to high
  localparam int NV = 5;
  localparam logic [35:0] VEC [NV] = '{
    {12'h000, 12'h7FF, 12'h000},
    {12'hFFF, 12'h7FF, 12'h7FF},
    {12'h0A5, 12'h0FF, 12'h0A5},
    {12'h5F0, 12'h30C, 12'h100},
    {12'h3C3, 12'h7FF, 12'h3C3}
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [3:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] a, output logic [3:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [10:0] s);
    src_req = s;
    @(negedge clk);
    src_req = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] d;
    logic [3:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R6 reset state
    for (int a = 0; a < 6; a++) begin
      do_rd(3'(a), d);
      chk("R6 reset register", d, 4'h0);
    end
    chk("R6 reset ien", {3'b0, ien}, 4'h0);
    chk("R7 reset irq", {3'b0, cpu_irq}, 4'h0);

    // R1 R5 R6 table walk
    for (int k = 0; k < NV; k++) begin
      logic [11:0] m, s, e;
      m = VEC[k][35:24]; s = VEC[k][23:12]; e = VEC[k][11:0];
      do_wr(3'd0, 4'hF); do_wr(3'd1, 4'hF); do_wr(3'd2, 4'hF);
      do_wr(3'd3, m[3:0]); do_wr(3'd4, m[7:4]); do_wr(3'd5, m[11:8]);
      pulse(s[10:0]);
      do_rd(3'd0, d); chk("R1 R5 pending0", d, e[3:0]);
      do_rd(3'd1, d); chk("R1 R5 pending1", d, e[7:4]);
      do_rd(3'd2, d); chk("R1 R5 pending2", d, e[11:8]);
      do_rd(3'd5, d); chk("R6 mask2 readback", d, m[11:8] & 4'h7);
    end

    // R3 partial clear and zero write
    do_wr(3'd0, 4'hF); do_wr(3'd1, 4'hF); do_wr(3'd2, 4'hF);
    do_wr(3'd3, 4'hF);
    pulse(11'h00F);
    do_wr(3'd0, 4'h5);
    do_rd(3'd0, d); chk("R3 clear ones", d, 4'hA);
    do_wr(3'd0, 4'h0);
    do_rd(3'd0, d); chk("R3 zero write keeps", d, 4'hA);

    // R4 request and clear on the same bit
    src_req = 11'h001; bus_addr = 3'd0; bus_wdata = 4'hF; bus_wr = 1'b1;
    @(negedge clk);
    src_req = '0; bus_wr = 1'b0;
    do_rd(3'd0, d); chk("R4 new request wins", d, 4'h1);

    // R10 R7 enable write and line
    chk("R7 irq off without enable", {3'b0, cpu_irq}, 4'h0);
    ien_we = 1'b1; ien_wdata = 1'b1;
    @(negedge clk);
    ien_we = 1'b0;
    chk("R10 enable written", {3'b0, ien}, 4'h1);
    @(negedge clk);
    chk("R7 irq asserted", {3'b0, cpu_irq}, 4'h1);

    // R9 R2 auto mode blocks line, capture still works
    auto_mode = 1'b1;
    @(negedge clk);
    chk("R9 auto blocks irq", {3'b0, cpu_irq}, 4'h0);
    do_wr(3'd4, 4'hF);
    pulse(11'h010);
    do_rd(3'd1, d); chk("R2 capture under auto", d, 4'h1);
    chk("R9 still blocked", {3'b0, cpu_irq}, 4'h0);
    auto_mode = 1'b0;
    @(negedge clk);
    chk("R9 released", {3'b0, cpu_irq}, 4'h1);

    // R2 capture with enable off
    ien_we = 1'b1; ien_wdata = 1'b0;
    @(negedge clk);
    ien_we = 1'b0;
    chk("R10 enable cleared", {3'b0, ien}, 4'h0);
    pulse(11'h020);
    do_rd(3'd1, d); chk("R2 capture enable off", d, 4'h3);
    chk("R7 irq off", {3'b0, cpu_irq}, 4'h0);

    // R9 halt under auto mode keeps enable
    auto_mode = 1'b1; halt_enter = 1'b1;
    @(negedge clk);
    halt_enter = 1'b0; auto_mode = 1'b0;
    chk("R9 halt blocked", {3'b0, ien}, 4'h0);

    // R8 halt beats enable write
    halt_enter = 1'b1; ien_we = 1'b1; ien_wdata = 1'b0;
    @(negedge clk);
    halt_enter = 1'b0; ien_we = 1'b0;
    chk("R8 halt forces enable", {3'b0, ien}, 4'h1);
    @(negedge clk);
    chk("R8 irq after halt", {3'b0, cpu_irq}, 4'h1);

    // R5 voltage-level source, R6 unused bit and address
    do_wr(3'd2, 4'hF);
    do_wr(3'd5, 4'hF);
    pulse(11'h400);
    do_rd(3'd2, d); chk("R5 vld position", d, 4'h4);
    held = d;
    do_rd(3'd5, d); chk("R6 mask bit3 unused", d, 4'h7);
    do_rd(3'd6, d); chk("R6 unused address", d, 4'h0);

    // R11 read data holds without strobe
    do_rd(3'd2, d);
    pulse(11'h100);
    @(negedge clk);
    chk("R11 rdata held", bus_rdata, held);
    do_rd(3'd2, d); chk("R11 fresh read", d, 4'h5);

    // R6 reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    do_rd(3'd2, d); chk("R6 pending after reset", d, 4'h0);
    do_rd(3'd5, d); chk("R6 mask after reset", d, 4'h0);
    chk("R6 enable after reset", {3'b0, ien}, 4'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule